// File: doc/BRIEF.md
# Register-Window Byte-Stream Packet Port

This block is the device end of a small packet interface that a host drives through a 32-bit register window. The host reads received packets one byte at a time from a fixed data port while a count register shows how many bytes are left. It sends a packet by first writing the packet length to a count register and then writing the packet's bytes, one per access, to a second fixed data port. On the network side there is one inbound byte stream and one outbound byte stream. Each stream uses a valid/ready handshake and carries a start-of-packet flag and the packet length. A single level interrupt line signals finished transmits, newly arrived receive data and a self-test request.

The block keeps no packet memory. Each direction holds one byte in a staging register. The inbound stream is stalled until the host has consumed the staged byte, and the outbound stream gets each byte as soon as the host writes it. The busy flag tells the host when a staging register is not ready for its next data-port access. While a received packet is still flagged as pending, no new packet is taken from the inbound stream.

Read data is combinational from the current state. The side effects of an access happen at the clock edge that ends it: a receive-port read pops a byte, and an interrupt-control read clears the test flag. Byte offsets of the window are 0x00/0x04 identifier, 0x08 busy, 0x0C receive count, 0x10 transmit count, 0x14 interrupt control, 0x18 interrupt routing, 0x1C receive data, 0x20 transmit data.

Top module: `pktport_top`

## Requirements
- R1: Offset 0x00 reads 0x50544B50 and offset 0x04 reads {VERSION, 0x54, 0x52, 0x4F}, which is 0x3154524F with the default VERSION. Together these spell an ASCII tag ending in a version character. Offset 0x18 reads the IRQ_ROUTE parameter (default 2).
- R2: After reset the busy, receive count, transmit count and interrupt control registers read 0, irq is low, out_valid is low and in_ready is high.
- R3: When idle with receive-available clear, a beat with in_start set and a nonzero in_len is accepted. The receive count (0x0C) is then loaded with in_len, interrupt-control bit 1 (receive-available) is set and irq goes high.
- R4: A read of 0x1C while busy is 0 and the receive count is nonzero returns the next packet byte in bits 7:0 with all upper bits 0, and it decrements the receive count by one.
- R5: A read of 0x1C when the receive count is 0, or while the next byte has not yet arrived, returns 0x00 and leaves the receive count unchanged.
- R6: While interrupt-control bit 1 is set and the receive count is 0, a packet start is not accepted (in_ready low). Once bit 1 is cleared, the start is accepted.
- R7: After a length N is written to 0x10, the next N writes to 0x20 appear on the outbound stream in order, bits 7:0 each. out_start is high only on the first byte and out_len equals N on every byte. 0x10 reads N until the packet is done.
- R8: On the handshake of the last programmed byte, interrupt-control bit 0 (transmit-done) is set and 0x10 reads 0. Writes to 0x20 beyond the programmed count produce no outbound byte.
- R9: Writing interrupt control clears bit 0 and bit 1 where the written bit is 1. Writing 0 to those bits leaves them set.
- R10: Writing interrupt control with bit 31 set raises bit 31 and irq. A read of interrupt control returns bit 31 set and then clears bit 31, but irq stays high until interrupt control is written with 0.
- R11: Bit 0 of 0x08 (busy) is 1 while a received byte is still awaited from the inbound stream or a written transmit byte is waiting for its outbound handshake, and 0 otherwise.
- R12: A transmit length of 65536 is accepted and reads back as 0x10000. A length above 65536, or 0, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| in_valid | input | 1 | Inbound byte valid |
| in_ready | output | 1 | Inbound byte accepted at this edge when valid |
| in_start | input | 1 | Inbound byte is the first of a packet |
| in_len | input | 17 | Inbound packet length, sampled with the start byte |
| in_data | input | 8 | Inbound byte |
| out_valid | output | 1 | Outbound byte valid |
| out_ready | input | 1 | Outbound sink ready |
| out_start | output | 1 | Outbound byte is the first of a packet |
| out_len | output | 17 | Outbound packet length |
| out_data | output | 8 | Outbound byte |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker watches several properties on every cycle. The receive count may only hold, step down by one, or load from zero. A start offered while receive-available is pending is never accepted. Receive-port reads at a zero count return zero, and a stalled outbound byte holds steady. A rising transmit-done comes with a cleared transmit count, and a test write is followed by irq. The directed scenarios are needed for the behaviours that depend on an ordered history: the byte order of both streams, write-one-to-clear against write-zero, the read-clears-then-write-zero sequence of the test bit, the ignored surplus transmit writes, and the limits on the transmit length.

// File: rtl/pktport_pkg.sv
package pktport_pkg;

    localparam int MAX_LEN = 65536;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int DATA_W  = 8;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 6;

    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_ID_LO  = 6'h00,
        REG_ID_HI  = 6'h04,
        REG_BUSY   = 6'h08,
        REG_RXCNT  = 6'h0C,
        REG_TXCNT  = 6'h10,
        REG_INTCTL = 6'h14,
        REG_ROUTE  = 6'h18,
        REG_RXDATA = 6'h1C,
        REG_TXDATA = 6'h20
    } reg_off_e;

    localparam int BIT_TXDONE  = 0;
    localparam int BIT_RXAVAIL = 1;
    localparam int BIT_TEST    = 31;

    typedef struct packed {
        logic test_flag;
        logic test_irq;
        logic rx_avail;
        logic tx_done;
    } irq_state_t;

    function automatic logic [63:0] make_id(input logic [7:0] ver);
        return {ver, 8'h54, 8'h52, 8'h4F, 8'h50, 8'h54, 8'h4B, 8'h50};
    endfunction

    function automatic logic [WORD_W-1:0] widen_len(input len_t v);
        return {{(WORD_W-LEN_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/pktport_rx.sv
module pktport_rx
    import pktport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_start,
    input  len_t  in_len,
    input  byte_t in_data,
    output logic  in_ready,
    input  logic  blocked,
    input  logic  pop,
    output len_t  cnt_o,
    output byte_t byte_o,
    output logic  busy_o,
    output logic  arrive_o
);
    len_t  cnt_q, fetch_q;
    logic  hold_vld;
    byte_t hold_q;
    logic  idle, take_start, take_next, pop_ok;

    assign idle       = (cnt_q == '0);
    assign in_ready   = idle ? !blocked : ((fetch_q != '0) && !hold_vld);
    assign take_start = idle && in_valid && in_ready && in_start && (in_len != '0);
    assign take_next  = !idle && in_valid && in_ready;
    assign pop_ok     = pop && hold_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            fetch_q  <= '0;
            hold_vld <= 1'b0;
            hold_q   <= '0;
        end else if (take_start) begin
            cnt_q    <= in_len;
            fetch_q  <= in_len - len_t'(1);
            hold_q   <= in_data;
            hold_vld <= 1'b1;
        end else if (take_next) begin
            hold_q   <= in_data;
            hold_vld <= 1'b1;
            fetch_q  <= fetch_q - len_t'(1);
        end else if (pop_ok) begin
            hold_vld <= 1'b0;
            cnt_q    <= cnt_q - len_t'(1);
        end
    end

    assign cnt_o    = cnt_q;
    assign byte_o   = hold_vld ? hold_q : '0;
    assign busy_o   = !idle && !hold_vld;
    assign arrive_o = take_start;
endmodule

// File: rtl/pktport_tx.sv
module pktport_tx
    import pktport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_len,
    input  logic              wr_byte,
    input  logic [WORD_W-1:0] wdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_start,
    output len_t              out_len,
    output byte_t             out_data,
    output len_t              cnt_o,
    output logic              busy_o,
    output logic              done_o
);
    len_t  len_q, wr_left, out_left;
    logic  hold_vld, first_q;
    byte_t hold_q;
    logic  accept_len, accept_byte, xfer;

    assign accept_len  = wr_len && (out_left == '0) && (wdata != '0)
                         && (wdata <= WORD_W'(MAX_LEN));
    assign accept_byte = wr_byte && (wr_left != '0) && !hold_vld;
    assign xfer        = hold_vld && out_ready;
    assign done_o      = xfer && (out_left == len_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q    <= '0;
            wr_left  <= '0;
            out_left <= '0;
            hold_vld <= 1'b0;
            hold_q   <= '0;
            first_q  <= 1'b0;
        end else begin
            if (accept_len) begin
                len_q    <= wdata[LEN_W-1:0];
                wr_left  <= wdata[LEN_W-1:0];
                out_left <= wdata[LEN_W-1:0];
                first_q  <= 1'b1;
            end
            if (accept_byte) begin
                hold_q   <= wdata[DATA_W-1:0];
                hold_vld <= 1'b1;
                wr_left  <= wr_left - len_t'(1);
            end else if (xfer) begin
                hold_vld <= 1'b0;
                first_q  <= 1'b0;
                out_left <= out_left - len_t'(1);
                if (done_o) len_q <= '0;
            end
        end
    end

    assign out_valid = hold_vld;
    assign out_start = first_q;
    assign out_len   = len_q;
    assign out_data  = hold_q;
    assign cnt_o     = len_q;
    assign busy_o    = hold_vld;
endmodule

// File: rtl/pktport_irq.sv
module pktport_irq
    import pktport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_tx,
    input  logic              set_rx,
    input  logic              wr,
    input  logic              rd,
    input  logic [WORD_W-1:0] wdata,
    output irq_state_t        st_o,
    output logic              irq_o
);
    irq_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (set_tx)                     st_q.tx_done <= 1'b1;
            else if (wr && wdata[BIT_TXDONE]) st_q.tx_done <= 1'b0;

            if (set_rx)                      st_q.rx_avail <= 1'b1;
            else if (wr && wdata[BIT_RXAVAIL]) st_q.rx_avail <= 1'b0;

            if (wr && wdata[BIT_TEST]) st_q.test_flag <= 1'b1;
            else if (rd)               st_q.test_flag <= 1'b0;

            if (wr && wdata[BIT_TEST])      st_q.test_irq <= 1'b1;
            else if (wr && (wdata == '0))   st_q.test_irq <= 1'b0;
        end
    end

    assign st_o  = st_q;
    assign irq_o = st_q.tx_done | st_q.rx_avail | st_q.test_irq;
endmodule

// File: rtl/pktport_top.sv
module pktport_top
    import pktport_pkg::*;
#(
    parameter logic [7:0]        VERSION   = 8'h31,
    parameter logic [WORD_W-1:0] IRQ_ROUTE = 32'd2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_start,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_start,
    output logic [LEN_W-1:0]  out_len,
    output logic [DATA_W-1:0] out_data,
    output logic              irq
);
    localparam logic [63:0] ID_VALUE = make_id(VERSION);

    logic       rd_rxdata, wr_txdata, wr_txcnt, rd_intctl, wr_intctl;
    len_t       rx_cnt, tx_cnt;
    byte_t      rx_byte;
    logic       rx_busy, tx_busy, rx_arrive, tx_done_evt;
    irq_state_t ist;
    logic       rx_avail_w, tx_done_w, test_irq_w;

    assign rd_rxdata = bus_rd && (bus_addr == REG_RXDATA);
    assign wr_txdata = bus_wr && (bus_addr == REG_TXDATA);
    assign wr_txcnt  = bus_wr && (bus_addr == REG_TXCNT);
    assign rd_intctl = bus_rd && (bus_addr == REG_INTCTL);
    assign wr_intctl = bus_wr && (bus_addr == REG_INTCTL);

    pktport_rx u_rx (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_start(in_start), .in_len(in_len),
        .in_data(in_data), .in_ready(in_ready),
        .blocked(ist.rx_avail), .pop(rd_rxdata),
        .cnt_o(rx_cnt), .byte_o(rx_byte), .busy_o(rx_busy),
        .arrive_o(rx_arrive)
    );

    pktport_tx u_tx (
        .clk(clk), .rst(rst),
        .wr_len(wr_txcnt), .wr_byte(wr_txdata), .wdata(bus_wdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_start(out_start),
        .out_len(out_len), .out_data(out_data),
        .cnt_o(tx_cnt), .busy_o(tx_busy), .done_o(tx_done_evt)
    );

    pktport_irq u_irq (
        .clk(clk), .rst(rst),
        .set_tx(tx_done_evt), .set_rx(rx_arrive),
        .wr(wr_intctl), .rd(rd_intctl), .wdata(bus_wdata),
        .st_o(ist), .irq_o(irq)
    );

    assign rx_avail_w = ist.rx_avail;
    assign tx_done_w  = ist.tx_done;
    assign test_irq_w = ist.test_irq;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_ID_LO:  bus_rdata = ID_VALUE[31:0];
            REG_ID_HI:  bus_rdata = ID_VALUE[63:32];
            REG_BUSY:   bus_rdata = {{(WORD_W-1){1'b0}}, rx_busy | tx_busy};
            REG_RXCNT:  bus_rdata = widen_len(rx_cnt);
            REG_TXCNT:  bus_rdata = widen_len(tx_cnt);
            REG_INTCTL: begin
                bus_rdata[BIT_TEST]    = ist.test_flag;
                bus_rdata[BIT_RXAVAIL] = ist.rx_avail;
                bus_rdata[BIT_TXDONE]  = ist.tx_done;
            end
            REG_ROUTE:  bus_rdata = IRQ_ROUTE;
            REG_RXDATA: bus_rdata = {{(WORD_W-DATA_W){1'b0}}, rx_byte};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pktport_checker.sv
module pktport_checker
    import pktport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_start,
    input logic              out_valid,
    input logic              out_ready,
    input logic [LEN_W-1:0]  out_len,
    input logic [DATA_W-1:0] out_data,
    input logic              irq,
    input logic [LEN_W-1:0]  rx_cnt,
    input logic [LEN_W-1:0]  tx_cnt,
    input logic              rx_avail,
    input logic              tx_done
);
    // R4: receive count only holds, steps down by one, or loads from zero
    p_rxcnt_step_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rx_cnt == $past(rx_cnt)) || (rx_cnt == $past(rx_cnt) - LEN_W'(1))
                 || ($past(rx_cnt) == '0));

    // R5: receive-port reads at zero count return zero
    p_rx_empty_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == REG_RXDATA && rx_cnt == '0) |-> (bus_rdata == '0));

    // R6: no packet start taken while receive-available is pending
    p_block_rx_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_avail && in_valid && in_start && rx_cnt == '0) |-> !in_ready);

    // R7: a stalled outbound byte stays put
    p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_len)));

    // R8: transmit-done rises together with a cleared transmit count
    p_txdone_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> (tx_cnt == '0));

    // R10: a test write raises the interrupt line
    p_test_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_INTCTL && bus_wdata[BIT_TEST]) |=> irq);
endmodule

bind pktport_top pktport_checker u_chk (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_start(in_start),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_len(out_len), .out_data(out_data), .irq(irq),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .rx_avail(rx_avail_w), .tx_done(tx_done_w)
);

// File: tb/pktport_top_test.sv
module pktport_top_test;
    import pktport_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [WORD_W-1:0] bus_wdata = '0;
    logic [WORD_W-1:0] bus_rdata;
    logic              in_valid = 1'b0, in_start = 1'b0;
    logic              in_ready;
    logic [LEN_W-1:0]  in_len = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid, out_start;
    logic              out_ready = 1'b1;
    logic [LEN_W-1:0]  out_len;
    logic [DATA_W-1:0] out_data;
    logic              irq;

    int n_cmp = 0, n_bad = 0;
    int cap_n = 0;
    logic [7:0]       cap_d [8];
    logic             cap_s [8];
    logic [LEN_W-1:0] cap_l [8];
    logic             timed_out = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pktport_top uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_start(in_start),
        .in_len(in_len), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_start(out_start), .out_len(out_len),
        .out_data(out_data), .irq(irq)
    );

    always @(negedge clk) begin
        #1;
        if (!rst && out_valid && out_ready && cap_n < 8) begin
            cap_d[cap_n] = out_data;
            cap_s[cap_n] = out_start;
            cap_l[cap_n] = out_len;
            cap_n++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic push(input logic st, input logic [LEN_W-1:0] len, input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_start = st; in_len = len; in_data = d;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(REG_BUSY, v);   chk("R2 busy", v, 0);
        rd(REG_RXCNT, v);  chk("R2 rxcnt", v, 0);
        rd(REG_TXCNT, v);  chk("R2 txcnt", v, 0);
        rd(REG_INTCTL, v); chk("R2 intctl", v, 0);
        chk("R2 irq", {31'b0, irq}, 0);
        chk("R2 out_valid", {31'b0, out_valid}, 0);
        chk("R2 in_ready", {31'b0, in_ready}, 1);
    endtask

    task automatic t_ident();
        logic [31:0] v;
        rd(REG_ID_LO, v); chk("R1 id_lo", v, 32'h50544B50);
        rd(REG_ID_HI, v); chk("R1 id_hi", v, 32'h3154524F);
        rd(REG_ROUTE, v); chk("R1 route", v, 32'd2);
    endtask

    task automatic t_rx_basic();
        logic [31:0] v;
        logic [7:0] pk [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
        push(1'b1, 17'd4, pk[0]);
        rd(REG_RXCNT, v);  chk("R3 rxcnt load", v, 4);
        rd(REG_INTCTL, v); chk("R3 rxavail bit", v, 32'h2);
        chk("R3 irq", {31'b0, irq}, 1);
        for (int i = 0; i < 4; i++) begin
            if (i > 0) begin
                rd(REG_BUSY, v);   chk("R11 rx busy awaiting byte", v, 1);
                rd(REG_RXDATA, v); chk("R5 read while awaiting", v, 0);
                rd(REG_RXCNT, v);  chk("R5 count kept", v, 4 - i);
                push(1'b0, 17'd4, pk[i]);
            end
            rd(REG_BUSY, v);   chk("R11 rx byte ready", v, 0);
            rd(REG_RXDATA, v); chk("R4 rx byte", v, {24'b0, pk[i]});
            rd(REG_RXCNT, v);  chk("R4 rxcnt step", v, 3 - i);
        end
        rd(REG_RXDATA, v); chk("R5 read at zero", v, 0);
        rd(REG_RXCNT, v);  chk("R5 count stays zero", v, 0);
    endtask

    task automatic t_block_and_w1c();
        logic [31:0] v;
        @(negedge clk);
        in_valid = 1'b1; in_start = 1'b1; in_len = 17'd1; in_data = 8'h5A;
        repeat (3) @(negedge clk);
        #1 chk("R6 start refused", {31'b0, in_ready}, 0);
        in_valid = 1'b0; in_start = 1'b0;
        rd(REG_RXCNT, v); chk("R6 no load", v, 0);
        wr(REG_INTCTL, 32'h0);
        rd(REG_INTCTL, v); chk("R9 write zero keeps bit1", v, 32'h2);
        wr(REG_INTCTL, 32'h1);
        rd(REG_INTCTL, v); chk("R9 bit0 write leaves bit1", v, 32'h2);
        wr(REG_INTCTL, 32'h2);
        rd(REG_INTCTL, v); chk("R9 bit1 cleared", v, 0);
        chk("R9 irq low", {31'b0, irq}, 0);
        push(1'b1, 17'd1, 8'h5A);
        rd(REG_RXCNT, v);  chk("R6 accepted after clear", v, 1);
        rd(REG_RXDATA, v); chk("R6 byte", v, 32'h5A);
        wr(REG_INTCTL, 32'h2);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        cap_n = 0;
        wr(REG_TXCNT, 32'd3);
        rd(REG_TXCNT, v); chk("R7 txcnt readback", v, 3);
        wr(REG_TXDATA, 32'hFFFF_FF11);
        wr(REG_TXDATA, 32'h22);
        wr(REG_TXDATA, 32'h33);
        repeat (2) @(negedge clk);
        rd(REG_INTCTL, v); chk("R8 txdone set", v, 32'h1);
        rd(REG_TXCNT, v);  chk("R8 txcnt cleared", v, 0);
        chk("R8 irq", {31'b0, irq}, 1);
        wr(REG_TXDATA, 32'h44);
        repeat (3) @(negedge clk);
        chk("R8 surplus ignored count", cap_n, 3);
        chk("R7 byte0", {24'b0, cap_d[0]}, 32'h11);
        chk("R7 byte1", {24'b0, cap_d[1]}, 32'h22);
        chk("R7 byte2", {24'b0, cap_d[2]}, 32'h33);
        chk("R7 start flags", {29'b0, cap_s[0], cap_s[1], cap_s[2]}, 32'h4);
        chk("R7 out_len", {15'b0, cap_l[0]}, 3);
        chk("R7 out_len last", {15'b0, cap_l[2]}, 3);
        wr(REG_INTCTL, 32'h1);
        rd(REG_INTCTL, v); chk("R9 bit0 cleared", v, 0);
    endtask

    task automatic t_tx_busy();
        logic [31:0] v;
        cap_n = 0;
        out_ready = 1'b0;
        wr(REG_TXCNT, 32'd1);
        wr(REG_TXDATA, 32'h77);
        rd(REG_BUSY, v); chk("R11 tx busy", v, 1);
        chk("R7 stalled valid", {31'b0, out_valid}, 1);
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rd(REG_BUSY, v); chk("R11 tx idle", v, 0);
        chk("R7 single byte", {23'b0, cap_s[0], cap_d[0]}, 32'h177);
        chk("R7 single count", cap_n, 1);
        wr(REG_INTCTL, 32'h1);
    endtask

    task automatic t_test_bit();
        logic [31:0] v;
        wr(REG_INTCTL, 32'h8000_0000);
        chk("R10 irq raised", {31'b0, irq}, 1);
        rd(REG_INTCTL, v); chk("R10 bit31 read", v, 32'h8000_0000);
        rd(REG_INTCTL, v); chk("R10 bit31 cleared by read", v, 0);
        chk("R10 irq held", {31'b0, irq}, 1);
        wr(REG_INTCTL, 32'h0);
        chk("R10 irq removed", {31'b0, irq}, 0);
    endtask

    task automatic t_maxlen();
        logic [31:0] v;
        wr(REG_TXCNT, 32'h0001_0001);
        rd(REG_TXCNT, v); chk("R12 oversize ignored", v, 0);
        wr(REG_TXCNT, 32'h0);
        rd(REG_TXCNT, v); chk("R12 zero ignored", v, 0);
        wr(REG_TXCNT, 32'h0001_0000);
        rd(REG_TXCNT, v); chk("R12 max accepted", v, 32'h1_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        fork
            begin
                t_reset();
                t_ident();
                t_rx_basic();
                t_block_and_w1c();
                t_tx();
                t_tx_busy();
                t_test_bit();
                t_maxlen();
            end
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=expired expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule